// File: doc/BRIEF.md
# Byte/Word Data Memory Access Unit

This unit stands between a processor's load/store port and a 16-bit data RAM made of two byte lanes. The lanes share one word index and have separate write enables. A request gives a 16-bit byte address, a size (byte or word), a direction and, for stores, the write data. Even addresses hold the low byte of a word and odd addresses hold the high byte. The RAM sits inside the unit. Its depth is set by a parameter.

The unit accepts one request per clock. Its response comes one clock later and carries the read data, an address-error trap flag and the post-incremented pointer.

A byte load fetches the containing word and returns the selected byte right-aligned. A byte store enables only the lane picked by address bit 0. A word access to an odd address raises the trap:
- a load still completes and returns the containing word;
- a store leaves the RAM untouched.

Addresses at or above the implemented size read as zero. Stores to them are dropped, with no trap.

Top module: `dmau_top`

## Requirements
- R1: While reset is held and on the first clock after it, rspValid, addrTrap and rspData are all zero.
- R2: reqReady is high after reset. A request accepted on a clock edge gives rspValid high for exactly the following cycle. Without a request, rspValid stays low.
- R3: A word load from an even, implemented address A returns byte A+1 in rspData[15:8] and byte A in rspData[7:0].
- R4: A byte load from an implemented address A returns byte A in rspData[7:0], with rspData[15:8] zero. Bit 0 of A selects the high lane (1) or the low lane (0).
- R5: A byte store to an implemented address A writes reqWdata[7:0] into byte A only. The other byte of that word keeps its value.
- R6: A word store to an even, implemented address A writes reqWdata[7:0] to byte A and reqWdata[15:8] to byte A+1.
- R7: A word load from an odd address A completes with addrTrap high and returns the word at A with bit 0 cleared.
- R8: A word store to an odd address raises addrTrap and changes no byte of the RAM.
- R9: Any load from an address at or above the implemented size (RAM_WORDS*2 bytes) returns zero. It raises no trap unless it is a word access to an odd address.
- R10: A store to an address at or above the implemented size changes no implemented byte and raises no trap unless misaligned.
- R11: With each response, rspNextAddr equals the request address plus 1 for a byte access or plus 2 for a word access, modulo 2^16.
- R12: addrTrap is high only in a response to a word access at an odd address. A byte access never traps. Every store response returns rspData zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqReady | output | 1 | Unit can take a request |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqWord | input | 1 | 1 = word access, 0 = byte access |
| reqAddr | input | 16 | Byte effective address |
| reqWdata | input | 16 | Store data; a byte store uses bits 7:0 |
| rspValid | output | 1 | Response present, one cycle after acceptance |
| rspData | output | 16 | Load data, byte results right-aligned |
| addrTrap | output | 1 | Address-error trap for a misaligned word access |
| rspNextAddr | output | 16 | Post-incremented pointer |

## Verification
Directed accesses cover the following cases:
- a byte store to each lane of one word, followed by a word load, which separates correct lane enables from writes of the full word;
- word accesses at odd addresses, which separate load completion from store suppression;
- accesses at and above the implemented limit, which expose aliasing into low memory;
- a pointer at 0xFFFF, which checks wrap-around.

Seeded random loads and stores, in both sizes and on both sides of the limit, are compared with a byte-array model. This catches errors in lane selection, byte placement and pointer steps that depend on the address.

// File: rtl/dmau_pkg.sv
package dmau_pkg;
  typedef struct packed {
    logic capture;  // request accepted this cycle
    logic wrLo;     // write enable, even byte lane
    logic wrHi;     // write enable, odd byte lane
    logic rdZero;   // response data forced to zero
    logic selHi;    // byte load takes the odd lane
    logic isWord;   // word-sized access
  } dmauStrobes_t;
endpackage

// File: rtl/dmau_ctrl.sv
module dmau_ctrl
  import dmau_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RAM_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic              addrTrap,
  output logic [ADDR_W-1:0] rspNextAddr,
  output dmauStrobes_t      strobes
);
  localparam int RAM_BYTES = RAM_WORDS * 2;

  logic readyQ;
  logic accept;
  logic misalign;
  logic inRange;
  logic wrEn;

  assign accept   = reqValid & readyQ;
  assign misalign = reqWord & reqAddr[0];
  assign inRange  = ({16'd0, reqAddr} < 32'(RAM_BYTES));
  assign wrEn     = accept & reqWrite & inRange & ~misalign;
  assign reqReady = readyQ;

  always_comb begin
    strobes.capture = accept;
    strobes.wrLo    = wrEn & (reqWord | ~reqAddr[0]);
    strobes.wrHi    = wrEn & (reqWord | reqAddr[0]);
    strobes.rdZero  = reqWrite | ~inRange;
    strobes.selHi   = ~reqWord & reqAddr[0];
    strobes.isWord  = reqWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ      <= 1'b0;
      rspValid    <= 1'b0;
      addrTrap    <= 1'b0;
      rspNextAddr <= '0;
    end else begin
      readyQ   <= 1'b1;
      rspValid <= accept;
      addrTrap <= accept & misalign;
      if (accept) begin
        rspNextAddr <= reqAddr + (reqWord ? ADDR_W'(2) : ADDR_W'(1));
      end
    end
  end
endmodule

// File: rtl/dmau_dpath.sv
module dmau_dpath
  import dmau_pkg::*;
#(
  parameter int RAM_WORDS = 256
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dmauStrobes_t                 strobes,
  input  logic [$clog2(RAM_WORDS)-1:0] wordIdx,
  input  logic [15:0]                  wdata,
  output logic [15:0]                  rspData
);
  logic [7:0]  memLo [RAM_WORDS];
  logic [7:0]  memHi [RAM_WORDS];
  logic [7:0]  hiIn;
  logic [15:0] rdWord;
  logic [15:0] rdSel;

  // byte stores carry data on the low lane; steer it to the odd lane too
  assign hiIn   = strobes.isWord ? wdata[15:8] : wdata[7:0];
  assign rdWord = {memHi[wordIdx], memLo[wordIdx]};

  always_comb begin
    if (strobes.rdZero)      rdSel = '0;
    else if (strobes.isWord) rdSel = rdWord;
    else if (strobes.selHi)  rdSel = {8'h00, rdWord[15:8]};
    else                     rdSel = {8'h00, rdWord[7:0]};
  end

  always_ff @(posedge clk) begin
    if (strobes.wrLo) memLo[wordIdx] <= wdata[7:0];
    if (strobes.wrHi) memHi[wordIdx] <= hiIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rspData <= '0;
    else if (strobes.capture) rspData <= rdSel;
  end
endmodule

// File: rtl/dmau_top.sv
module dmau_top
  import dmau_pkg::*;
#(
  parameter int RAM_WORDS = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic        reqWord,
  input  logic [15:0] reqAddr,
  input  logic [15:0] reqWdata,
  output logic        rspValid,
  output logic [15:0] rspData,
  output logic        addrTrap,
  output logic [15:0] rspNextAddr
);
  localparam int IDX_W = $clog2(RAM_WORDS);

  dmauStrobes_t strobesW;

  dmau_ctrl #(.ADDR_W(16), .RAM_WORDS(RAM_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqReady(reqReady),
    .rspValid(rspValid), .addrTrap(addrTrap), .rspNextAddr(rspNextAddr),
    .strobes(strobesW)
  );

  dmau_dpath #(.RAM_WORDS(RAM_WORDS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobesW),
    .wordIdx(reqAddr[IDX_W:1]), .wdata(reqWdata), .rspData(rspData)
  );
endmodule

// File: rtl/dmau_chk.sv
module dmau_chk
  import dmau_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         reqValid,
  input logic         reqReady,
  input logic         reqWrite,
  input logic         reqWord,
  input logic [15:0]  reqAddr,
  input logic         rspValid,
  input logic [15:0]  rspData,
  input logic         addrTrap,
  input logic [15:0]  rspNextAddr,
  input dmauStrobes_t strobes
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);  // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid);  // R2
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWord) |=> (rspData[15:8] == 8'h00));  // R4
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWord) |-> $onehot0({strobes.wrLo, strobes.wrHi}));  // R5
  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqWord && reqAddr[0]) |-> !(strobes.wrLo || strobes.wrHi));  // R8
  AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWord) |=> (rspNextAddr == $past(reqAddr) + 16'd2));  // R11
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !(reqWord && reqAddr[0])) |=> !addrTrap);  // R12
  AST_TRAP_WITH_RSP: assert property (@(posedge clk) disable iff (!rstN)
    addrTrap |-> rspValid);  // R12
endmodule

bind dmau_top dmau_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .reqWord(reqWord), .reqAddr(reqAddr),
  .rspValid(rspValid), .rspData(rspData), .addrTrap(addrTrap),
  .rspNextAddr(rspNextAddr), .strobes(strobesW)
);

// File: tb/sim_dmau_top.sv
module sim_dmau_top;
  localparam int CLK_PERIOD = 10;
  localparam int RAM_WORDS  = 256;
  localparam int RAM_BYTES  = RAM_WORDS * 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic reqReady, rspValid, addrTrap;
  logic [15:0] rspData, rspNextAddr;

  int vectors = 0;
  int fails = 0;
  logic [7:0] model [RAM_BYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmau_top #(.RAM_WORDS(RAM_WORDS)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqWord(reqWord), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .addrTrap(addrTrap), .rspNextAddr(rspNextAddr)
  );

  function automatic logic [7:0] mByte(input int a);
    return (a < RAM_BYTES) ? model[a] : 8'h00;
  endfunction

  function automatic logic [15:0] expData(input logic wr, input logic wd, input logic [15:0] a);
    int base;
    if (wr) return 16'h0000;                                    // R12
    if (wd) begin
      base = int'(a) & 32'hFFFE;                                // R3 R7 R9
      return {mByte(base + 1), mByte(base)};
    end
    return {8'h00, mByte(int'(a))};                             // R4 R9
  endfunction

  task automatic access(input logic wr, input logic wd, input logic [15:0] a,
                        input logic [15:0] wdat, input string tag);
    logic [15:0] eData, eNext;
    logic eTrap;
    eData = expData(wr, wd, a);
    eTrap = wd & a[0];
    eNext = a + (wd ? 16'd2 : 16'd1);
    reqValid = 1'b1; reqWrite = wr; reqWord = wd; reqAddr = a; reqWdata = wdat;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    vectors++;
    if (rspValid !== 1'b1 || rspData !== eData || addrTrap !== eTrap || rspNextAddr !== eNext) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b word=%0b: got v=%0b d=%h t=%0b n=%h exp v=1 d=%h t=%0b n=%h",
               tag, a, wr, wd, rspValid, rspData, addrTrap, rspNextAddr, eData, eTrap, eNext);
    end
    if (wr && !eTrap && int'(a) < RAM_BYTES) begin               // R5 R6 R8 R10
      model[int'(a)] = wdat[7:0];
      if (wd) model[int'(a) + 1] = wdat[15:8];
    end
  endtask

  task automatic checkIdle(input string tag);
    @(negedge clk);
    vectors++;
    if (rspValid !== 1'b0 || addrTrap !== 1'b0) begin
      fails++;
      $display("FAIL %s: got v=%0b t=%0b exp v=0 t=0", tag, rspValid, addrTrap);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] a;
    int r;
    r = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    vectors++;
    if (rspValid !== 1'b0 || addrTrap !== 1'b0 || rspData !== 16'h0) begin
      fails++;
      $display("FAIL R1 reset: got v=%0b t=%0b d=%h exp 0 0 0000", rspValid, addrTrap, rspData);
    end
    rstN = 1'b1;
    @(negedge clk);
    vectors++;
    if (reqReady !== 1'b1 || rspValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 R2 after reset: got rdy=%0b v=%0b exp 1 0", reqReady, rspValid);
    end
    // preload the whole implemented range with word stores (R6)
    for (int i = 0; i < RAM_BYTES; i += 2)
      access(1'b1, 1'b1, 16'(i), 16'(i * 16'h0101 + 16'h3C5A), "R6 fill");
    for (int i = 0; i < 8; i++) access(1'b0, 1'b1, 16'(2 * i), 16'h0, "R3 word read");
    checkIdle("R2 idle");
    // byte lanes
    access(1'b1, 1'b0, 16'h0010, 16'hFFA1, "R5 byte write even");
    access(1'b1, 1'b0, 16'h0011, 16'hEEB2, "R5 byte write odd");
    access(1'b0, 1'b1, 16'h0010, 16'h0, "R5 word readback");
    access(1'b0, 1'b0, 16'h0010, 16'h0, "R4 byte read even");
    access(1'b0, 1'b0, 16'h0011, 16'h0, "R4 byte read odd");
    // misaligned
    access(1'b0, 1'b1, 16'h0021, 16'h0, "R7 misaligned read");
    access(1'b1, 1'b1, 16'h0031, 16'hDEAD, "R8 misaligned write");
    access(1'b0, 1'b1, 16'h0030, 16'h0, "R8 readback");
    // limit
    access(1'b0, 1'b1, 16'(RAM_BYTES - 2), 16'h0, "R3 last word");
    access(1'b0, 1'b1, 16'(RAM_BYTES), 16'h0, "R9 first beyond");
    access(1'b0, 1'b0, 16'(RAM_BYTES + 1), 16'h0, "R9 byte beyond");
    access(1'b1, 1'b1, 16'(RAM_BYTES + 4), 16'h1357, "R10 write beyond");
    access(1'b1, 1'b0, 16'(RAM_BYTES + 5), 16'h0099, "R10 byte write beyond");
    access(1'b0, 1'b1, 16'h0004, 16'h0, "R10 alias check");
    access(1'b0, 1'b1, 16'(RAM_BYTES + 4), 16'h0, "R9 R10 readback beyond");
    access(1'b0, 1'b1, 16'hFFFF, 16'h0, "R11 R7 wrap word");
    access(1'b0, 1'b0, 16'hFFFF, 16'h0, "R11 R9 wrap byte");
    checkIdle("R2 idle after burst");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      r = $urandom;
      a = (r[3:0] == 4'h0) ? 16'($urandom) : 16'($urandom_range(RAM_BYTES + 31, 0));
      access(r[4], r[5], a, 16'($urandom), "R3-12 random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule